// File: doc/BRIEF.md
# Power and Sleep Controller

This block gates the clocks and drives the resets of a set of peripheral modules. The modules are grouped into a small number of power domains. Software talks to it over a simple 32-bit register bus with byte addresses and word-aligned registers. Changes are made in two steps:

1. Software writes the state it wants for each module and the power state it wants for each domain. Nothing changes yet.
2. Software writes a per-domain go command. The block then sequences the change and commits it to every module of that domain at the same moment.

Powering up a domain that is off adds a handshake. The block raises a power request for the domain and waits until software confirms that power is good. Software confirms after it has switched the domain on outside this block.

Each module has a clock-enable output and an active-low reset output. The reset output follows two things: the committed module state and a local reset bit. The local reset bit acts at once and needs no transition.

A transition that takes a running module out of its enabled state waits for that module's idle input, unless the force flag of that module is set. The module count, domain count, module-to-domain map and transition latency are all parameters.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After reset, every module status reads 0 in bits 5:0 with bit 12 clear. Every `mod_clk_en` is 0 and every `mod_rst_n` is 0. Every domain status reads 0, which means off. The busy register (0x128) and the power-request register (0x070) read 0. Module control (0xA00+4n) reads 0x100.
- R2: Writing module control bits 5:0 does not change module status. Suppose a 1 is written to bit d of the go register (0x120) and no power-up handshake is needed. Then bit d of 0x128 reads 1 for exactly LAT cycles. After that, each module of domain d shows its requested state in status bits 5:0, and modules of other domains are unchanged.
- R3: Domain d may be off (status 0x200+4d bits 4:0 equal 0) when a go is issued with domain control (0x300+4d) bit 0 set. In that case bit d of 0x070 is set and busy stays set. Both hold until domain control bit 8 is written 1. Bit d of 0x070 clears one cycle later, and the transition completes LAT cycles after that, with the domain status reading 1.
- R4: A go on a domain whose domain control bit 0 is 0 completes after LAT cycles with the domain status reading 0.
- R5: A go bit written while its domain is busy is ignored. The pending transition still completes at its original time.
- R6: `mod_clk_en[n]` is 1 exactly when the committed state of module n is 3 (enable). Module status bit 12 reads the same value. It changes only when a transition commits.
- R7: `mod_rst_n[n]` is 0 when the committed state is 0 or 1, or when module control bit 8 is 0. Writing bit 8 takes effect in the next cycle, without a go command.
- R8: A commit that takes a module out of state 3 waits while that module's `mod_idle` is 0 and module control bit 31 is 0. With bit 31 set, it completes after LAT cycles regardless of `mod_idle`.
- R9: Reads of unmapped offsets, or of indices beyond the module or domain count, return 0. Writes to 0x070, 0x128, 0x200+4d and 0x800+4n have no effect. Module control reads back bits 5:0, 8 and 31 as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | AW | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| mod_idle | input | N_MOD | Per-module idle acknowledge |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst_n | output | N_MOD | Per-module active-low reset |

## Verification
The hardest situations to reach from the ports are a transition stalled in one of two ways:

- **Waiting for power-good.** The stimulus powers a domain up, then keeps the power-good bit clear for several cycles before confirming it.
- **Waiting for module idle.** The stimulus enables a module, then holds its idle input low and requests a lower state without force.

In both cases the bench sees the domain stay busy past its normal latency. The transition must release exactly one cycle after the condition is met. A second go written into an active transition must not stretch its completion time. Random rounds then program random states and local-reset values on both domains and check every status word and output pin against a model in the bench.

// File: rtl/psc_pkg.sv
package psc_pkg;

  // Register byte offsets
  localparam logic [11:0] OFF_PWRREQ = 12'h070;
  localparam logic [11:0] OFF_GO     = 12'h120;
  localparam logic [11:0] OFF_BUSY   = 12'h128;
  localparam logic [11:0] OFF_DSTAT  = 12'h200;
  localparam logic [11:0] OFF_DCTL   = 12'h300;
  localparam logic [11:0] OFF_MSTAT  = 12'h800;
  localparam logic [11:0] OFF_MCTL   = 12'hA00;

  // Module state codes (6-bit field)
  localparam logic [5:0] MS_OFFRST  = 6'd0;
  localparam logic [5:0] MS_SYNCRST = 6'd1;
  localparam logic [5:0] MS_GATED   = 6'd2;
  localparam logic [5:0] MS_RUN     = 6'd3;

  typedef enum logic [1:0] {
    DS_IDLE  = 2'd0,
    DS_PWAIT = 2'd1,
    DS_COUNT = 2'd2
  } dseq_t;

  function automatic logic clk_active(input logic [5:0] st);
    return st == MS_RUN;
  endfunction

  function automatic logic held_in_reset(input logic [5:0] st, input logic lrst_n);
    return (st == MS_OFFRST) || (st == MS_SYNCRST) || !lrst_n;
  endfunction

  function automatic logic leaves_run(input logic [5:0] cur, input logic [5:0] nxt);
    return (cur == MS_RUN) && (nxt != MS_RUN);
  endfunction

endpackage

// File: rtl/psc_mod_slot.sv
module psc_mod_slot
  import psc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [31:0] ctl_wdata,
  input  logic        commit,
  input  logic        idle,
  output logic [31:0] ctl_q,
  output logic [31:0] stat_q,
  output logic        leave_run,
  output logic        force_q,
  output logic        ready,
  output logic        clk_en,
  output logic        rst_out_n
);

  logic [5:0] nxt_st;
  logic [5:0] cur_st;
  logic       lrst_n;
  logic       unused_bits;

  assign unused_bits = ^{ctl_wdata[30:9], ctl_wdata[7:6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_st  <= MS_OFFRST;
      lrst_n  <= 1'b1;
      force_q <= 1'b0;
    end else if (ctl_we) begin
      nxt_st  <= ctl_wdata[5:0];
      lrst_n  <= ctl_wdata[8];
      force_q <= ctl_wdata[31];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_st <= MS_OFFRST;
    else if (commit) cur_st <= nxt_st;
  end

  assign leave_run = leaves_run(cur_st, nxt_st);
  assign ready     = !leave_run || idle || force_q;
  assign clk_en    = clk_active(cur_st);
  assign rst_out_n = !held_in_reset(cur_st, lrst_n);

  always_comb begin
    ctl_q       = '0;
    ctl_q[5:0]  = nxt_st;
    ctl_q[8]    = lrst_n;
    ctl_q[31]   = force_q;
    stat_q      = '0;
    stat_q[5:0] = cur_st;
    stat_q[12]  = clk_en;
  end

endmodule

// File: rtl/psc_dom_seq.sv
module psc_dom_seq
  import psc_pkg::*;
#(
  parameter int unsigned LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic want_on,
  input  logic pgood,
  input  logic mods_ready,
  output logic busy,
  output logic pwr_req,
  output logic pwr_on,
  output logic accept,
  output logic done
);

  localparam int unsigned CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(LAT - 1);

  dseq_t         st;
  logic [CW-1:0] cnt;
  logic          tgt;

  assign busy   = (st != DS_IDLE);
  assign accept = go && (st == DS_IDLE);
  assign done   = (st == DS_COUNT) && (cnt == '0) && mods_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= DS_IDLE;
      cnt     <= '0;
      tgt     <= 1'b0;
      pwr_req <= 1'b0;
      pwr_on  <= 1'b0;
    end else begin
      case (st)
        DS_IDLE: begin
          if (accept) begin
            tgt <= want_on;
            if (want_on && !pwr_on) begin
              pwr_req <= 1'b1;
              st      <= DS_PWAIT;
            end else begin
              cnt <= CNT_LOAD;
              st  <= DS_COUNT;
            end
          end
        end
        DS_PWAIT: begin
          if (pgood) begin
            pwr_req <= 1'b0;
            cnt     <= CNT_LOAD;
            st      <= DS_COUNT;
          end
        end
        DS_COUNT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (mods_ready) begin
            pwr_on <= tgt;
            st     <= DS_IDLE;
          end
        end
        default: st <= DS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import psc_pkg::*;
#(
  parameter int unsigned N_MOD = 4,
  parameter int unsigned N_DOM = 2,
  parameter logic [N_MOD*4-1:0] MOD_DOM_MAP = 16'h1100,
  parameter int unsigned LAT = 4,
  parameter int unsigned AW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [N_MOD-1:0] mod_idle,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic [N_MOD-1:0] mod_rst_n
);

  function automatic logic [AW-1:0] slot_addr(input logic [11:0] base, input int unsigned idx);
    return AW'(32'(base) + 4 * idx);
  endfunction

  // Named internal events, also used by the checker
  logic             wr_go;
  logic [N_DOM-1:0] dom_go, dom_busy, dom_pwr_req, dom_on, dom_accept, dom_done, dom_ready;
  logic [N_DOM-1:0] pd_next, pd_good, pd_ctl_we;
  logic [N_MOD-1:0] mod_ctl_we, mod_commit, mod_leave_run, mod_force, mod_ready, mod_lrst_n;
  logic [31:0]      mod_ctl  [N_MOD];
  logic [31:0]      mod_stat [N_MOD];

  assign wr_go = reg_wr && (reg_addr == AW'(OFF_GO));

  // Domain control registers and sequencers
  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign pd_ctl_we[d] = reg_wr && (reg_addr == slot_addr(OFF_DCTL, d));
    assign dom_go[d]    = wr_go && reg_wdata[d];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pd_next[d] <= 1'b0;
        pd_good[d] <= 1'b0;
      end else if (pd_ctl_we[d]) begin
        pd_next[d] <= reg_wdata[0];
        pd_good[d] <= reg_wdata[8];
      end
    end

    psc_dom_seq #(.LAT(LAT)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (dom_go[d]),
      .want_on    (pd_next[d]),
      .pgood      (pd_good[d]),
      .mods_ready (dom_ready[d]),
      .busy       (dom_busy[d]),
      .pwr_req    (dom_pwr_req[d]),
      .pwr_on     (dom_on[d]),
      .accept     (dom_accept[d]),
      .done       (dom_done[d])
    );
  end

  // A domain is ready when every module mapped to it is ready
  always_comb begin
    dom_ready = '1;
    for (int d = 0; d < N_DOM; d++) begin
      for (int m = 0; m < N_MOD; m++) begin
        if ((int'(MOD_DOM_MAP[4*m +: 4]) == d) && !mod_ready[m]) dom_ready[d] = 1'b0;
      end
    end
  end

  // Module slots
  for (genvar m = 0; m < N_MOD; m++) begin : g_mod
    localparam int unsigned DI = int'(MOD_DOM_MAP[4*m +: 4]);
    assign mod_ctl_we[m] = reg_wr && (reg_addr == slot_addr(OFF_MCTL, m));
    assign mod_commit[m] = dom_done[DI];
    assign mod_lrst_n[m] = mod_ctl[m][8];

    psc_mod_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (mod_ctl_we[m]),
      .ctl_wdata (reg_wdata),
      .commit    (mod_commit[m]),
      .idle      (mod_idle[m]),
      .ctl_q     (mod_ctl[m]),
      .stat_q    (mod_stat[m]),
      .leave_run (mod_leave_run[m]),
      .force_q   (mod_force[m]),
      .ready     (mod_ready[m]),
      .clk_en    (mod_clk_en[m]),
      .rst_out_n (mod_rst_n[m])
    );
  end

  // Read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_addr == AW'(OFF_PWRREQ)) reg_rdata[N_DOM-1:0] = dom_pwr_req;
    if (reg_addr == AW'(OFF_BUSY))   reg_rdata[N_DOM-1:0] = dom_busy;
    for (int d = 0; d < N_DOM; d++) begin
      if (reg_addr == slot_addr(OFF_DSTAT, d)) reg_rdata[0] = dom_on[d];
      if (reg_addr == slot_addr(OFF_DCTL, d)) begin
        reg_rdata[0] = pd_next[d];
        reg_rdata[8] = pd_good[d];
      end
    end
    for (int m = 0; m < N_MOD; m++) begin
      if (reg_addr == slot_addr(OFF_MSTAT, m)) reg_rdata = mod_stat[m];
      if (reg_addr == slot_addr(OFF_MCTL, m))  reg_rdata = mod_ctl[m];
    end
  end

endmodule

// File: rtl/psc_chk.sv
module psc_chk #(
  parameter int unsigned N_MOD = 4,
  parameter int unsigned N_DOM = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DOM-1:0] dom_busy,
  input logic [N_DOM-1:0] dom_go,
  input logic [N_DOM-1:0] dom_done,
  input logic [N_DOM-1:0] dom_pwr_req,
  input logic [N_DOM-1:0] pd_good,
  input logic [N_MOD-1:0] mod_commit,
  input logic [N_MOD-1:0] mod_leave_run,
  input logic [N_MOD-1:0] mod_force,
  input logic [N_MOD-1:0] mod_idle,
  input logic [N_MOD-1:0] mod_clk_en,
  input logic [N_MOD-1:0] mod_rst_n,
  input logic [N_MOD-1:0] mod_lrst_n
);

  for (genvar d = 0; d < N_DOM; d++) begin : g_d
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      dom_done[d] |=> !dom_busy[d]); // R2
    AST_BUSY_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_busy[d]) |-> $past(dom_go[d])); // R2
    AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      dom_go[d] && dom_busy[d] && !dom_done[d] |=> dom_busy[d]); // R5
    AST_REQ_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      dom_pwr_req[d] |-> dom_busy[d]); // R3
    AST_REQ_DROP_NEEDS_PG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_pwr_req[d]) |-> $past(pd_good[d])); // R3
  end

  for (genvar m = 0; m < N_MOD; m++) begin : g_m
    AST_CLK_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mod_clk_en[m]) |-> $past(mod_commit[m])); // R6
    AST_IDLE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      mod_commit[m] && mod_leave_run[m] |-> mod_idle[m] || mod_force[m]); // R8
    AST_LRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_lrst_n[m] |-> !mod_rst_n[m]); // R7
  end

endmodule

bind pwr_sleep_ctrl psc_chk #(.N_MOD(N_MOD), .N_DOM(N_DOM)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dom_busy      (dom_busy),
  .dom_go        (dom_go),
  .dom_done      (dom_done),
  .dom_pwr_req   (dom_pwr_req),
  .pd_good       (pd_good),
  .mod_commit    (mod_commit),
  .mod_leave_run (mod_leave_run),
  .mod_force     (mod_force),
  .mod_idle      (mod_idle),
  .mod_clk_en    (mod_clk_en),
  .mod_rst_n     (mod_rst_n),
  .mod_lrst_n    (mod_lrst_n)
);

// File: tb/test_pwr_sleep_ctrl.sv
module test_pwr_sleep_ctrl;

  localparam int NM  = 4;
  localparam int ND  = 2;
  localparam int LAT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NM-1:0] mod_idle = '1;
  logic [NM-1:0] mod_clk_en;
  logic [NM-1:0] mod_rst_n;

  int nchk = 0;
  int nerr = 0;
  logic [5:0] exp_st [NM];
  logic       exp_lr [NM];

  always #5 clk = ~clk;

  pwr_sleep_ctrl #(.N_MOD(NM), .N_DOM(ND), .MOD_DOM_MAP(16'h1100), .LAT(LAT), .AW(12)) i_pwr_sleep_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mod_idle(mod_idle), .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
  );

  // Bench model: modules 0,1 in domain 0, modules 2,3 in domain 1
  function automatic int dom_of(input int m);
    return (m < 2) ? 0 : 1;
  endfunction
  function automatic logic [31:0] stat_word(input logic [5:0] st);
    return {19'd0, (st == 6'd3), 6'd0, st};
  endfunction
  function automatic logic rst_expect(input logic [5:0] st, input logic lr);
    return !((st < 6'd2) || !lr);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_mods(input string req);
    logic [31:0] v;
    for (int m = 0; m < NM; m++) begin
      rd(12'h800 + 12'(4*m), v);
      chk(req, v, stat_word(exp_st[m]));
      chk(req, 32'(mod_clk_en[m]), 32'(exp_st[m] == 6'd3));
      chk(req, 32'(mod_rst_n[m]), 32'(rst_expect(exp_st[m], exp_lr[m])));
    end
  endtask

  task automatic power_on(input int d);
    logic [31:0] v;
    wr(12'h300 + 12'(4*d), 32'h1);
    wr(12'h120, 32'(1 << d));
    rd(12'h070, v); chk("R3 req set", v[d], 1);
    cyc(6);
    rd(12'h128, v); chk("R3 busy waits for power-good", v[d], 1);
    rd(12'h070, v); chk("R3 req held", v[d], 1);
    wr(12'h300 + 12'(4*d), 32'h101);
    cyc(1);
    rd(12'h070, v); chk("R3 req cleared", v[d], 0);
    cyc(LAT - 1);
    rd(12'h128, v); chk("R3 busy before latency", v[d], 1);
    cyc(1);
    rd(12'h128, v); chk("R3 busy done", v[d], 0);
    rd(12'h200 + 12'(4*d), v); chk("R3 domain on", v, 32'h1);
  endtask

  task automatic go_and_time(input int d, input string req);
    logic [31:0] v;
    wr(12'h120, 32'(1 << d));
    cyc(LAT - 1);
    rd(12'h128, v); chk(req, v[d], 1);
    cyc(1);
    rd(12'h128, v); chk(req, v[d], 0);
    for (int m = 0; m < NM; m++) begin
      if (dom_of(m) == d) exp_st[m] = i_ctl_shadow[m][5:0];
    end
  endtask

  logic [31:0] i_ctl_shadow [NM];

  task automatic wctl(input int m, input logic [31:0] d);
    wr(12'hA00 + 12'(4*m), d);
    i_ctl_shadow[m] = d;
    exp_lr[m] = d[8];
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int m = 0; m < NM; m++) begin
      exp_st[m] = 6'd0; exp_lr[m] = 1'b1; i_ctl_shadow[m] = 32'h100;
    end
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    check_mods("R1 module reset");
    for (int d = 0; d < ND; d++) begin
      rd(12'h200 + 12'(4*d), v); chk("R1 domain off", v, 0);
    end
    rd(12'h128, v); chk("R1 busy", v, 0);
    rd(12'h070, v); chk("R1 power request", v, 0);
    rd(12'hA00, v); chk("R1 control reset", v, 32'h100);

    // R9 unmapped and read-only
    rd(12'h004, v); chk("R9 unmapped", v, 0);
    rd(12'h810, v); chk("R9 module index beyond", v, 0);
    rd(12'h208, v); chk("R9 domain index beyond", v, 0);
    wr(12'h800, 32'h3);   rd(12'h800, v); chk("R9 status write ignored", v, 0);
    wr(12'h128, 32'h3);   rd(12'h128, v); chk("R9 busy write ignored", v, 0);
    wr(12'h200, 32'h1);   rd(12'h200, v); chk("R9 domain status write ignored", v, 0);
    wr(12'h070, 32'h3);   rd(12'h070, v); chk("R9 request write ignored", v, 0);
    wr(12'hA0C, 32'h8000_0102); rd(12'hA0C, v); chk("R9 control readback", v, 32'h8000_0102);
    wctl(3, 32'h100);

    // R3 power-up handshake on both domains
    power_on(0);
    power_on(1);

    // R2 two-phase commit
    wctl(0, 32'h103);
    wctl(1, 32'h102);
    cyc(2);
    rd(12'h800, v); chk("R2 no change before go", v, 0);
    go_and_time(0, "R2 latency");
    check_mods("R2 commit domain 0 only");
    chk("R6 clk_en on enable", 32'(mod_clk_en[0]), 1);

    // R7 local reset acts at once
    wctl(0, 32'h003);
    chk("R7 local reset asserted", 32'(mod_rst_n[0]), 0);
    chk("R6 clock unaffected by local reset", 32'(mod_clk_en[0]), 1);
    wctl(0, 32'h103);
    chk("R7 local reset released", 32'(mod_rst_n[0]), 1);

    // R5 go while busy is ignored
    wctl(1, 32'h101);
    wr(12'h120, 32'h1);
    wr(12'h120, 32'h1);
    cyc(LAT - 3);
    rd(12'h128, v); chk("R5 busy at original time-1", v[0], 1);
    cyc(1);
    rd(12'h128, v); chk("R5 done at original time", v[0], 0);
    exp_st[0] = 6'd3; exp_st[1] = 6'd1;
    check_mods("R5 commit");

    // R8 idle handshake without force
    mod_idle[0] = 1'b0;
    wctl(0, 32'h102);
    wr(12'h120, 32'h1);
    cyc(LAT + 3);
    rd(12'h128, v); chk("R8 stalled on idle", v[0], 1);
    chk("R8 clock still running", 32'(mod_clk_en[0]), 1);
    mod_idle[0] = 1'b1;
    cyc(1);
    rd(12'h128, v); chk("R8 released by idle", v[0], 0);
    exp_st[0] = 6'd2;
    check_mods("R8 commit after idle");

    // R8 force bypasses idle
    wctl(0, 32'h103);
    go_and_time(0, "R8 re-enable");
    mod_idle[0] = 1'b0;
    wctl(0, 32'h8000_0102);
    go_and_time(0, "R8 forced latency");
    check_mods("R8 forced commit");
    mod_idle[0] = 1'b1;

    // R4 power off domain 1
    wr(12'h304, 32'h0);
    go_and_time(1, "R4 latency");
    rd(12'h204, v); chk("R4 domain off", v, 0);
    check_mods("R4 modules");

    // Random rounds (R2, R6, R7)
    v = $urandom(32'h5eed_0001);
    for (int it = 0; it < 24; it++) begin
      int mask;
      for (int m = 0; m < NM; m++) begin
        logic [31:0] c;
        c = 32'h8000_0000 | 32'($urandom_range(0, 3)) | (32'($urandom_range(0, 1)) << 8);
        wctl(m, c);
      end
      check_mods("R7 random local reset");
      mask = $urandom_range(1, 3);
      wr(12'h120, 32'(mask));
      cyc(LAT);
      rd(12'h128, v); chk("R2 random busy cleared", v, 0);
      for (int m = 0; m < NM; m++) begin
        if (mask[dom_of(m)]) exp_st[m] = i_ctl_shadow[m][5:0];
      end
      check_mods("R6 random commit");
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule